// File: doc/BRIEF.md
# GPIO Interrupt Routing Controller

This block turns the pins of a 32-line general-purpose input port into interrupt requests. It synchronizes each pin and treats each line as either a level source or a rising-edge source. A per-line enable gates every line. A per-line route field then steers the line to any one of a parameterized number of interrupt outputs. When several lines share a route value, their requests are merged onto the same output.

Software programs the block through a small word-addressed register bus. The bus gives access to a trigger-type register, an enable register, eight route words and a read-only capability word. Interrupt output index `x` stands for interrupt number base + x, where the base is the first interrupt number assigned to the block.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, the trigger-type, enable and route registers read zero and `irq_o` is all zeros.
- R2: A line with trigger bit 0 (level) and enable bit 1 drives its routed output high while the pin is high. An output rises on the third rising clock edge after the pin rises, and falls on the third rising clock edge after the pin falls.
- R3: A line with trigger bit 1 (edge) and enable bit 1 produces a one-cycle pulse on its routed output for each rising transition of the pin. The pulse is high for the cycle after the third rising clock edge following the transition. A pin held high or falling produces nothing.
- R4: A line whose enable bit is 0 never raises any output, whatever its route value. Setting the enable bit while a level-type pin is high raises the output on the second rising edge after the bus write is presented.
- R5: A line whose route field holds value x drives `irq_o[x]`, for any x from 0 to NUM_IRQ-1.
- R6: Lines that share a route value are ORed onto that one output, so the output stays high while any of them is active.
- R7: The route word at offset 0x20 + 4*n holds the fields for lines 4n to 4n+3, for n = 0 to 7. Line 4n uses bits 28:24, line 4n+1 uses bits 20:16, line 4n+2 uses bits 12:8 and line 4n+3 uses bits 4:0. All other bits read zero and ignore writes.
- R8: A route value of NUM_IRQ or above produces no interrupt on any output.
- R9: The capability word at offset 0x1C reads (NUM_LINES-1) in bits 4:0 and (NUM_IRQ-1) in bits 12:8. Bits 18:16 read zero because the flag, input-enable and pulse registers are absent. All other bits read zero, and writes to this word have no effect.
- R10: The trigger-type register sits at offset 0x14 and the enable register at 0x18; both read back what was written. Reads of unmapped offsets return zero, and writes to other offsets leave these registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during a read strobe, zero otherwise |
| pin_i | input | NUM_LINES | Asynchronous input pins |
| irq_o | output | NUM_IRQ | Interrupt request outputs, index 0 is the base interrupt |

## Verification
The bench builds the block with its defaults: NUM_LINES = 32 and NUM_IRQ = 16. Because the route field is 5 bits wide, these values leave route codes 16 to 31 unused, so the out-of-range rule can be exercised. They also place the top output, index 15, within reach of the last line in the last route word. A scoreboard checks the output timing of level, edge and merged sources cycle by cycle. The capability word is checked against the parameter values.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int MAP_W       = 5;
  localparam int LANES       = 4;
  localparam int LANE_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFS_EDGE = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MAP0 = 8'h20;

  // lowest bit of the route field for lane k inside a route word
  function automatic int lane_lsb(int lane);
    return (LANES - 1 - lane) * LANE_STRIDE;
  endfunction

  // byte offset of route word w
  function automatic logic [ADDR_W-1:0] map_ofs(int word);
    return ADDR_W'(int'(OFS_MAP0) + 4 * word);
  endfunction

  // capability word: line count - 1, output count - 1, optional regs absent
  function automatic logic [DATA_W-1:0] cap_word(int nlines, int nirq);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[4:0]   = 5'(nlines - 1);
    w[12:8]  = 5'(nirq - 1);
    w[18:16] = 3'b000;
    return w;
  endfunction

  // true when a route field selects output j
  function automatic logic route_hit(logic [MAP_W-1:0] field, int j);
    return int'(field) == j;
  endfunction
endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage
  #(parameter int NUM_LINES = 32)
  (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [NUM_LINES-1:0] edge_sel_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic [NUM_LINES-1:0] line_req_o,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_LINES-1:0] level_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign level_ev = sync2_q;
  assign rise_o   = sync2_q & ~prev_q;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      line_req_o[i] = mask_i[i] & (edge_sel_i[i] ? rise_o[i] : level_ev[i]);
  end

  // R3: a rising-transition event never lasts two cycles
  p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_irq_pkg::*;
  #(parameter int NUM_LINES = 32,
    parameter int NUM_IRQ   = 16)
  (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel_i,
  input  logic                         bus_wr_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [DATA_W-1:0]            bus_wdata_i,
  output logic [DATA_W-1:0]            bus_rdata_o,
  output logic [NUM_LINES-1:0]         edge_o,
  output logic [NUM_LINES-1:0]         mask_o,
  output logic [NUM_LINES*MAP_W-1:0]   map_o
);
  localparam int NWORDS = NUM_LINES / LANES;
  localparam logic [DATA_W-1:0] CAP_VAL = cap_word(NUM_LINES, NUM_IRQ);

  logic [NUM_LINES-1:0] edge_q, mask_q;
  logic [MAP_W-1:0]     map_q [NUM_LINES];
  logic                 wr_en, rd_en;
  logic [DATA_W-1:0]    rd_mux;

  assign wr_en = bus_sel_i & bus_wr_i;
  assign rd_en = bus_sel_i & ~bus_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (bus_addr_i == OFS_EDGE) edge_q <= bus_wdata_i[NUM_LINES-1:0];
      if (bus_addr_i == OFS_MASK) mask_q <= bus_wdata_i[NUM_LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) map_q[i] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NWORDS; w++)
        if (bus_addr_i == map_ofs(w))
          for (int k = 0; k < LANES; k++)
            map_q[w*LANES+k] <= bus_wdata_i[lane_lsb(k) +: MAP_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == OFS_EDGE) rd_mux[NUM_LINES-1:0] = edge_q;
    if (bus_addr_i == OFS_MASK) rd_mux[NUM_LINES-1:0] = mask_q;
    if (bus_addr_i == OFS_CAP)  rd_mux = CAP_VAL;
    for (int w = 0; w < NWORDS; w++)
      if (bus_addr_i == map_ofs(w))
        for (int k = 0; k < LANES; k++)
          rd_mux[lane_lsb(k) +: MAP_W] = map_q[w*LANES+k];
  end

  assign bus_rdata_o = rd_en ? rd_mux : '0;
  assign edge_o      = edge_q;
  assign mask_o      = mask_q;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) map_o[i*MAP_W +: MAP_W] = map_q[i];
  end

  // R10: a write to any other offset leaves the trigger-type register alone
  p_edge_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr_i != OFS_EDGE) |=> $stable(edge_q));

  // R10: a write to any other offset leaves the enable register alone
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr_i != OFS_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
  #(parameter int NUM_LINES = 32,
    parameter int NUM_IRQ   = 16)
  (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       line_req_i,
  input  logic [NUM_LINES*MAP_W-1:0] map_i,
  output logic [NUM_IRQ-1:0]         irq_o
);
  logic [NUM_IRQ-1:0] irq_next, irq_q;

  // route values >= NUM_IRQ match no output and are dropped
  always_comb begin
    irq_next = '0;
    for (int j = 0; j < NUM_IRQ; j++)
      for (int i = 0; i < NUM_LINES; i++)
        if (line_req_i[i] && route_hit(map_i[i*MAP_W +: MAP_W], j))
          irq_next[j] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_next;
  end

  assign irq_o = irq_q;

  // R5: an active output always has an active line behind it
  p_irq_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> $past(|line_req_i));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
  #(parameter int NUM_LINES = 32,
    parameter int NUM_IRQ   = 16)
  (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [7:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_IRQ-1:0]   irq_o
);
  logic [NUM_LINES-1:0]       edge_sel, mask, line_req, rise_ev;
  logic [NUM_LINES*MAP_W-1:0] map_flat;

  gpio_reg_file #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .edge_o(edge_sel), .mask_o(mask), .map_o(map_flat)
  );

  gpio_in_stage #(.NUM_LINES(NUM_LINES)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .edge_sel_i(edge_sel), .mask_i(mask),
    .line_req_o(line_req), .rise_o(rise_ev)
  );

  gpio_irq_route #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_route (
    .clk(clk), .rst_n(rst_n), .line_req_i(line_req),
    .map_i(map_flat), .irq_o(irq_o)
  );

  // R4: with every enable bit clear no line requests anything
  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (line_req == '0));
endmodule

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  localparam int NL = 32;
  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic [NL-1:0] pins = '0;
  logic [NI-1:0] irq;
  int            cyc = 0;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  typedef struct {int due; logic [NI-1:0] val; string tag;} exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_irq_router u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pin_i(pins), .irq_o(irq)
  );

  // monitor: pops scoreboard items when their cycle arrives
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_run++;
      if (e.due != cyc || irq !== e.val) begin
        n_fail++;
        $display("FAIL %s irq: actual %h expected %h (cycle %0d due %0d)",
                 e.tag, irq, e.val, cyc, e.due);
      end
    end
  end

  task automatic expect_irq(int dly, logic [NI-1:0] v, string tag);
    sbq.push_back('{cyc + dly, v, tag});
  endtask

  task automatic check_val(logic [31:0] act, logic [31:0] exp, string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read_check(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check_val(bus_rdata, exp, tag);
    bus_sel = 1'b0;
  endtask

  task automatic set_pin(int line, logic v);
    @(negedge clk);
    pins[line] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    check_val(32'(irq), 32'h0, "R1 irq after reset");
    bus_read_check(8'h14, 32'h0, "R1 trigger reg reset");
    bus_read_check(8'h18, 32'h0, "R1 enable reg reset");
    bus_read_check(8'h20, 32'h0, "R1 route word0 reset");
    bus_read_check(8'h3C, 32'h0, "R1 route word7 reset");

    // R9: capability word, read-only
    bus_read_check(8'h1C, 32'h0000_0F1F, "R9 capability");
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_read_check(8'h1C, 32'h0000_0F1F, "R9 capability after write");

    // R10: trigger and enable readback, unmapped offsets
    bus_write(8'h14, 32'hA5A5_0000);
    bus_write(8'h18, 32'h1234_5678);
    bus_read_check(8'h14, 32'hA5A5_0000, "R10 trigger readback");
    bus_read_check(8'h18, 32'h1234_5678, "R10 enable readback");
    bus_read_check(8'h00, 32'h0, "R10 unmapped read");
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read_check(8'h14, 32'hA5A5_0000, "R10 trigger after foreign write");
    bus_read_check(8'h18, 32'h1234_5678, "R10 enable after foreign write");
    bus_write(8'h14, 32'h0);
    bus_write(8'h18, 32'h0);

    // R7: route word layout and reserved bits
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_read_check(8'h24, 32'h1F1F_1F1F, "R7 reserved bits read zero");
    bus_write(8'h3C, 32'h0A0B_0C0D);
    bus_read_check(8'h3C, 32'h0A0B_0C0D, "R7 route word7 readback");
    bus_write(8'h24, 32'h0);
    bus_write(8'h3C, 32'h0);

    // R2 / R5: level line 5 routed to output 3
    bus_write(8'h24, 32'h0003_0000);
    bus_write(8'h18, 32'h0000_0020);
    set_pin(5, 1'b1);
    expect_irq(2, 16'h0000, "R2 level not yet");
    expect_irq(3, 16'h0008, "R2 level rise");
    expect_irq(6, 16'h0008, "R2 level held");
    idle(7);
    set_pin(5, 1'b0);
    expect_irq(2, 16'h0008, "R2 level before fall");
    expect_irq(3, 16'h0000, "R2 level fall");
    idle(5);

    // R3: edge line 9 routed to output 7
    bus_write(8'h28, 32'h0007_0000);
    bus_write(8'h14, 32'h0000_0200);
    bus_write(8'h18, 32'h0000_0220);
    set_pin(9, 1'b1);
    expect_irq(2, 16'h0000, "R3 edge not yet");
    expect_irq(3, 16'h0080, "R3 edge pulse");
    expect_irq(4, 16'h0000, "R3 pulse one cycle");
    expect_irq(7, 16'h0000, "R3 held pin silent");
    idle(8);
    set_pin(9, 1'b0);
    expect_irq(3, 16'h0000, "R3 falling silent");
    expect_irq(4, 16'h0000, "R3 falling silent later");
    idle(6);
    set_pin(9, 1'b1);
    expect_irq(3, 16'h0080, "R3 second pulse");
    expect_irq(4, 16'h0000, "R3 second pulse ends");
    idle(6);
    set_pin(9, 1'b0);
    bus_write(8'h14, 32'h0);
    bus_write(8'h18, 32'h0);
    idle(4);

    // R4: enable gating on line 12 routed to output 2
    bus_write(8'h2C, 32'h0200_0000);
    set_pin(12, 1'b1);
    expect_irq(3, 16'h0000, "R4 disabled line silent");
    expect_irq(6, 16'h0000, "R4 disabled line still silent");
    idle(7);
    bus_write(8'h18, 32'h0000_1000);
    expect_irq(1, 16'h0004, "R4 enable raises output");
    idle(3);
    bus_write(8'h18, 32'h0);
    expect_irq(1, 16'h0000, "R4 disable drops output");
    idle(3);
    set_pin(12, 1'b0);
    idle(4);

    // R6: lines 0 and 1 merged onto output 4
    bus_write(8'h20, 32'h0404_0000);
    bus_write(8'h18, 32'h0000_0003);
    set_pin(0, 1'b1);
    expect_irq(3, 16'h0010, "R6 first source");
    set_pin(1, 1'b1);
    expect_irq(3, 16'h0010, "R6 both sources");
    set_pin(0, 1'b0);
    expect_irq(3, 16'h0010, "R6 second source keeps output");
    set_pin(1, 1'b0);
    expect_irq(3, 16'h0000, "R6 all sources gone");
    idle(5);

    // R8: line 2 routed to 20, beyond the 16 outputs
    bus_write(8'h20, 32'h0000_1400);
    bus_write(8'h18, 32'h0000_0004);
    set_pin(2, 1'b1);
    expect_irq(3, 16'h0000, "R8 out-of-range silent");
    expect_irq(5, 16'h0000, "R8 out-of-range still silent");
    idle(6);
    set_pin(2, 1'b0);
    idle(4);

    // R7: line 3 uses bits 4:0 of word 0, routed to 9
    bus_write(8'h20, 32'h0000_0009);
    bus_write(8'h18, 32'h0000_0008);
    set_pin(3, 1'b1);
    expect_irq(3, 16'h0200, "R7 lane 3 field routes");
    idle(5);
    set_pin(3, 1'b0);
    idle(4);

    // R5: last line to top output 15
    bus_write(8'h3C, 32'h0000_000F);
    bus_write(8'h18, 32'h8000_0000);
    set_pin(31, 1'b1);
    expect_irq(3, 16'h8000, "R5 top output");
    idle(5);
    set_pin(31, 1'b0);
    expect_irq(3, 16'h0000, "R5 top output clears");
    idle(6);

    done = 1'b1;
    report();
  end
endmodule